// File: doc/BRIEF.md
# Staggered Core Activation Controller

Each core in a shared power domain has one of these controllers. It sits between the core's switch-on and switch-off requests and the core's power control line. A core that switches draws or releases a step of supply current, and that step excites the ringing of the supply network. The controller holds this core's step until it falls in a quiet interval that follows the most recent switching event of a neighbour.

A free-running cycle counter restarts at zero on every switching pulse from a neighbour core and saturates at its top value. Up to eight programmable windows, each an inclusive range of counter values with a valid bit, mark where this core's step does least harm. A pending request is granted in any cycle where the counter is saturated or lies inside a valid window. Otherwise the request waits while the counter climbs into the next window. A granted change shows on the registered control output one cycle later. At the same moment a one-cycle pulse goes out, so the controllers of the other cores can restart their own counters.

Top module: `stagger_ctrl`

## Requirements
- R1: After reset, `pwr_on` and `evt_out` are 0, all eight windows are disabled, and the counter holds its saturated value of 1023.
- R2: With the counter saturated, a pending request is granted at once, so `pwr_on` changes on the first clock edge after the request is sampled.
- R3: A `peer_evt` sampled high sets the counter to 0 at that edge. The counter then rises by one on each later edge.
- R4: Window k covers counter values c with `start <= c <= end` while its valid bit is 1. A pending request is granted in any cycle where the counter lies inside any valid window, with no added delay.
- R5: A request made while the counter lies outside every valid window, and is not saturated, is held until the counter reaches the start of a valid window.
- R6: While `pwr_on` is 0, a request to turn on is `req_on`=1 with `req_off`=0. While `pwr_on` is 1, a request to turn off is `req_off`=1 with `req_on`=0. Both kinds of request pass through the same window rule.
- R7: A request that is withdrawn before it is granted is dropped, and `pwr_on` does not change.
- R8: `evt_out` is high for exactly the cycles in which `pwr_on` has just changed value.
- R9: A request input that is held high changes `pwr_on` only once.
- R10: A write with `cfg_we`=1 loads start, end and valid into pair `cfg_addr`. A pair with valid 0, or with start greater than end, matches no counter value.
- R11: The counter stops at 1023. A saturated counter counts as quiet even when no window covers 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_on | input | 1 | Level request to switch the core on |
| req_off | input | 1 | Level request to switch the core off |
| peer_evt | input | 1 | Switching pulse from any other core in the domain |
| cfg_we | input | 1 | Window write enable |
| cfg_addr | input | 3 | Window pair index |
| cfg_start | input | 10 | First quiet counter value |
| cfg_end | input | 10 | Last quiet counter value |
| cfg_valid | input | 1 | Enable for the written pair |
| pwr_on | output | 1 | Registered power control for this core |
| evt_out | output | 1 | One-cycle pulse when `pwr_on` changes |

## Verification
The assertions assume that `peer_evt` and the request levels are synchronous to `clk`. They also assume that `rst_n` is low at time zero, so the checker sees no unreset state. The stimulus drives every input just after a rising edge, and it holds reset low for several cycles at the start. It places requests before, inside and after the programmed windows, withdraws one request, and includes a run of more than 1023 cycles without peer pulses. It also writes one disabled pair and one pair whose start is greater than its end, so the window matching stays within the cases the requirements define.

// File: rtl/stagger_pkg.sv
// Package: shared widths and the window record type for the controller.
// Assumes a single counter width used by every instance in the domain.
package stagger_pkg;
    parameter int CNT_W = 10;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic vld;
        cnt_t lo;
        cnt_t hi;
    } win_t;
endpackage

// File: rtl/win_bank.sv
// Module: window register bank with a parallel range compare.
// Holds NUM_WIN inclusive ranges of counter values. Asserts hit when the
// count lies in any valid range. Assumes writes are synchronous to clk.
module win_bank
    import stagger_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int ADDR_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  cnt_t              lo,
    input  cnt_t              hi,
    input  logic              vld,
    input  cnt_t              cnt,
    output logic              hit
);
    win_t             bank [NUM_WIN];
    logic [NUM_WIN-1:0] in_win;

    genvar g;
    generate
        for (g = 0; g < NUM_WIN; g++) begin : g_win
            // Loads one pair on a matching write, clears on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bank[g] <= '0;
                end else if (we && (addr == ADDR_W'(g))) begin
                    bank[g] <= '{vld: vld, lo: lo, hi: hi};
                end
            end

            // Range test of the current count against this pair.
            always_comb begin
                in_win[g] = bank[g].vld && (cnt >= bank[g].lo) && (cnt <= bank[g].hi);
            end
        end
    endgenerate

    // Any pair matching makes the current cycle quiet.
    always_comb begin
        hit = |in_win;
    end
endmodule

// File: rtl/gap_counter.sv
// Module: cycles-since-peer-event counter.
// Restarts at zero on a peer pulse and stops at its top value. Comes out
// of reset saturated, so a first request meets no pending event.
module gap_counter
    import stagger_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output cnt_t cnt,
    output logic sat
);
    // Counts up after each restart, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_MAX;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flags the saturated value as quiet.
    always_comb begin
        sat = (cnt == CNT_MAX);
    end
endmodule

// File: rtl/grant_unit.sv
// Module: request qualification and the registered power output.
// A request is pending when it asks for the state the output does not
// hold and the opposite request is low. Assumes request levels are synchronous.
module grant_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic req_on,
    input  logic req_off,
    input  logic quiet,
    output logic pending,
    output logic pwr_on,
    output logic evt_out
);
    logic grant;

    // Works out whether a change is asked for and allowed now.
    always_comb begin
        pending = pwr_on ? (req_off && !req_on) : (req_on && !req_off);
        grant   = pending && quiet;
    end

    // Flips the output on a grant and marks that cycle with a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_on  <= 1'b0;
            evt_out <= 1'b0;
        end else begin
            pwr_on  <= pwr_on ^ grant;
            evt_out <= grant;
        end
    end
endmodule

// File: rtl/stagger_ctrl.sv
// Module: top of the staggered activation controller for one core.
// Joins the peer-event counter, the window bank and the grant logic.
// Assumes all inputs are synchronous to clk.
module stagger_ctrl
    import stagger_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int ADDR_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_on,
    input  logic              req_off,
    input  logic              peer_evt,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_start,
    input  logic [CNT_W-1:0]  cfg_end,
    input  logic              cfg_valid,
    output logic              pwr_on,
    output logic              evt_out
);
    cnt_t cnt;
    logic sat;
    logic hit;
    logic quiet;
    logic pending;

    gap_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (peer_evt),
        .cnt     (cnt),
        .sat     (sat)
    );

    win_bank #(.NUM_WIN(NUM_WIN)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .lo    (cfg_start),
        .hi    (cfg_end),
        .vld   (cfg_valid),
        .cnt   (cnt),
        .hit   (hit)
    );

    // Quiet when a window matches or the counter has run out.
    always_comb begin
        quiet = hit || sat;
    end

    grant_unit u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_on  (req_on),
        .req_off (req_off),
        .quiet   (quiet),
        .pending (pending),
        .pwr_on  (pwr_on),
        .evt_out (evt_out)
    );
endmodule

// File: rtl/stagger_ctrl_chk.sv
// Module: property checker bound into stagger_ctrl.
// Assumes rst_n is low at time zero.
module stagger_ctrl_chk
    import stagger_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic peer_evt,
    input logic pwr_on,
    input logic evt_out,
    input logic pending,
    input cnt_t cnt
);
    // R8
    evt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out == (pwr_on != $past(pwr_on)));

    // R2
    sat_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && pending) |=> evt_out);

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peer_evt |=> (cnt == '0));

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !peer_evt) |=> (cnt == CNT_MAX));

    // R7
    no_req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> $stable(pwr_on));
endmodule

bind stagger_ctrl stagger_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .peer_evt (peer_evt),
    .pwr_on   (pwr_on),
    .evt_out  (evt_out),
    .pending  (pending),
    .cnt      (cnt)
);

// File: tb/stagger_ctrl_test.sv
// Bench: behavioural reference model compared on every clock.
module stagger_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_on = 1'b0, req_off = 1'b0, peer_evt = 1'b0;
    logic       cfg_we = 1'b0, cfg_valid = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [9:0] cfg_start = '0, cfg_end = '0;
    logic       pwr_on, evt_out;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // reference state
    int m_cnt = 1023;
    bit m_pwr = 0, m_evt = 0;
    int m_lo[8], m_hi[8];
    bit m_vld[8];

    always #2 clk = ~clk;

    stagger_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
        .peer_evt(peer_evt), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_valid(cfg_valid),
        .pwr_on(pwr_on), .evt_out(evt_out)
    );

    task automatic check(string tag, string what, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Advance one clock: model the edge from current inputs, then compare.
    task automatic tick(string tag);
        bit hit = (m_cnt == 1023);
        bit pend, grant;
        for (int i = 0; i < 8; i++)
            if (m_vld[i] && m_cnt >= m_lo[i] && m_cnt <= m_hi[i]) hit = 1;
        pend  = m_pwr ? (req_off && !req_on) : (req_on && !req_off);
        grant = rst_n && pend && hit;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_cnt = 1023; m_pwr = 0; m_evt = 0;
            for (int i = 0; i < 8; i++) m_vld[i] = 0;
        end else begin
            if (cfg_we) begin
                m_lo[cfg_addr] = cfg_start; m_hi[cfg_addr] = cfg_end; m_vld[cfg_addr] = cfg_valid;
            end
            m_pwr = m_pwr ^ grant;
            m_evt = grant;
            m_cnt = peer_evt ? 0 : ((m_cnt < 1023) ? m_cnt + 1 : 1023);
        end
        check(tag, "pwr_on", pwr_on, m_pwr);
        check(tag, "evt_out", evt_out, m_evt);
    endtask

    task automatic ticks(string tag, int n);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic wr(int a, int lo, int hi, bit v);
        cfg_we = 1; cfg_addr = 3'(a); cfg_start = 10'(lo); cfg_end = 10'(hi); cfg_valid = v;
        tick("R10");
        cfg_we = 0;
    endtask

    task automatic peer(string tag);
        peer_evt = 1; tick(tag); peer_evt = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_vld[i] = 0; end
        ticks("R1", 4);
        rst_n = 1;
        tick("R1");
        check("R1", "pwr_on reset", pwr_on, 1'b0);
        check("R1", "evt_out reset", evt_out, 1'b0);

        // R2: saturated counter, immediate on, then held level (R9)
        req_on = 1; tick("R2");
        check("R2", "on after one edge", pwr_on, 1'b1);
        ticks("R9", 5);
        check("R9", "single change", pwr_on, 1'b1);
        req_on = 0; tick("R9");

        // program windows: 0:[20,30], 1:[50,55], 3 disabled [5,8], 4 inverted [40,35]
        wr(0, 20, 30, 1);
        wr(1, 50, 55, 1);
        wr(3, 5, 8, 0);
        wr(4, 40, 35, 1);

        // R5/R6: off request at count ~2, waits for 20
        peer("R3");
        ticks("R3", 2);
        req_off = 1;
        ticks("R5", 25);
        check("R6", "off granted", pwr_on, 1'b0);
        req_off = 0; tick("R6");

        // R4: on request inside window 1
        peer("R3");
        ticks("R4", 51);
        req_on = 1; tick("R4");
        check("R4", "granted in window", pwr_on, 1'b1);
        req_on = 0; tick("R4");

        // R10: requests at counts inside disabled and inverted pairs wait
        peer("R10");
        ticks("R10", 5);
        req_off = 1; ticks("R10", 3);
        check("R10", "disabled pair ignored", pwr_on, 1'b1);
        ticks("R10", 30);
        req_off = 0; tick("R10");
        req_on = 0;

        // R7: withdraw before a window
        peer("R7");
        ticks("R7", 31);
        req_on = 1; req_off = 0;
        tick("R7");
        req_on = 0; req_off = 0;
        ticks("R7", 1);
        peer("R7");
        ticks("R7", 3);
        req_on = 1; ticks("R7", 2); req_on = 0;
        ticks("R7", 40);

        // R11: long quiet run saturates, request granted at once
        peer("R11");
        ticks("R11", 1030);
        req_on = !m_pwr; req_off = m_pwr;
        tick("R11");
        check("R11", "saturated grant", evt_out, 1'b1);
        req_on = 0; req_off = 0;
        ticks("R11", 3);

        // R8: back-to-back peer pulses with a request waiting
        peer("R8"); peer("R8");
        req_on = !m_pwr; req_off = m_pwr;
        ticks("R8", 60);
        req_on = 0; req_off = 0; tick("R8");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule